// File: doc/BRIEF.md
# Cache Maintenance Operation Controller

This block runs cache maintenance requests against the tag state of a set-associative, write-back data cache. The processor presents an operation code, a target address and a request strobe. The controller looks up the tag state and updates the valid, dirty and tag fields. When a dirty line has to leave the cache, it also runs a line flush on a shared memory bus. The flush pushes one word per cycle and then goes straight back to idle. It never refills the line.

Five operations act on the line that the address hits: invalidate, write back, write back and invalidate, and forced forms of the last two that flush even a clean line. A sixth operation, set-line, claims a way for a new tag without reading memory. If the way it takes holds dirty data, set-line flushes that data first.

Line data is not kept here. During a flush the controller drives a registered way/set/word select toward the cache data array. It expects the selected word back combinationally on `dat_rdata`. A request is honoured only when the controller is idle and the bus is granted in that same cycle. Every other request gets a stall response, and the processor must retry.

Top module: `cache_maint_ctrl`

## Requirements
- R1: A request (`op_req` high at a clock edge) is accepted only if the controller is idle and `bus_gnt` is high at that edge. The cycle after the edge shows `op_ack`=1 for an accepted request, or `op_stall`=1 for a refused one. A refused request changes no cache state.
- R2: Code 0 (hit-invalidate) clears the valid bit of the way that hits, with no bus beats. On a miss it changes nothing.
- R3: Code 1 (write back) and code 2 (write back then invalidate) flush the line only when it hits and is dirty. A clean hit or a miss completes with no bus beats.
- R4: Code 3 (forced write back) and code 4 (forced write back then invalidate) flush the line on any hit, dirty or clean. A miss produces no beats.
- R5: A flush makes exactly 8 beats on 8 consecutive cycles, starting two cycles after the accepting edge. Beat i carries address line_base + 4*i and the data-array word at way `dat_way`, set `dat_set`, word `dat_word`=i. `bus_hold` is high from the cycle after acceptance through the last beat and low on the cycle after it.
- R6: At the end of a flush the line's dirty bit is cleared. Codes 2 and 4 also clear its valid bit.
- R7: Code 5 (set-line) has no effect when the address already hits. On a miss it takes the lowest-numbered invalid way of the set and marks it valid and clean with the new tag, with no bus beats.
- R8: If set-line misses and every way is valid, it takes the way with the oldest access stamp, the lowest-numbered way on a tie. If that way is clean, it is replaced at once. If it is dirty, its old line is flushed first, and then the new tag is installed valid and clean.
- R9: A store notification (`st_req`) that hits while the controller is idle and `op_req` is low marks the line dirty and refreshes its access stamp. A notification that misses, or that comes while the controller is busy or a request is present, is ignored.
- R10: Codes 6 and 7 are accepted with no effect.
- R11: Address fields are as follows: bits [1:0] select the byte, bits [4:2] the word, bits [10:5] the set and bits [31:11] the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_req | input | 1 | Maintenance request strobe |
| op_code | input | 3 | Operation code |
| op_addr | input | 32 | Target byte address |
| bus_gnt | input | 1 | Shared bus is free for this controller |
| st_req | input | 1 | Store-hit notification |
| st_addr | input | 32 | Address of the store |
| dat_rdata | input | 32 | Data-array word at the selected way/set/word |
| op_ack | output | 1 | Request was accepted on the previous edge |
| op_stall | output | 1 | Request was refused on the previous edge |
| bus_hold | output | 1 | Controller owns the shared bus |
| wb_valid | output | 1 | Write beat strobe |
| wb_addr | output | 32 | Write beat address |
| wb_data | output | 32 | Write beat data |
| dat_way | output | 2 | Data-array way select |
| dat_set | output | 6 | Data-array set select |
| dat_word | output | 3 | Data-array word select |

## Verification
The assertions take for granted that `dat_rdata` follows the select outputs within the same cycle. They also assume the processor holds each request for a single cycle and retries only after it has seen the response. The stimulus drives requests one cycle at a time and waits for the response before deciding whether to retry. It also waits for any flush to drain before the next store notification. Flushes are therefore never back to back, so the beat-address step check only ever sees beats from one line. Stall cases are produced deliberately, by dropping `bus_gnt` and by issuing a request while a flush is still running.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [2:0] {
    OP_HIT_INV   = 3'd0,
    OP_HIT_WB    = 3'd1,
    OP_HIT_WBINV = 3'd2,
    OP_FWB       = 3'd3,
    OP_FWBINV    = 3'd4,
    OP_SETLINE   = 3'd5,
    OP_RSV6      = 3'd6,
    OP_RSV7      = 3'd7
  } mop_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FLUSH = 1'b1
  } mst_e;

endpackage

// File: rtl/cmc_way.sv
// Per-way tag state: valid/dirty flops plus tag and stamp arrays with
// asynchronous read and synchronous write (distributed-RAM style).
module cmc_way #(
  parameter int SETS = 64,
  parameter int TAGW = 21,
  parameter int TSW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic                    rd_valid,
  output logic                    rd_dirty,
  output logic [TAGW-1:0]         rd_tag,
  output logic [TSW-1:0]          rd_ts,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic                    wr_v_en,
  input  logic                    wr_v,
  input  logic                    wr_d_en,
  input  logic                    wr_d,
  input  logic                    wr_tag_en,
  input  logic [TAGW-1:0]         wr_tag,
  input  logic                    wr_ts_en,
  input  logic [TSW-1:0]          wr_ts
);

  logic [SETS-1:0] v_q;
  logic [SETS-1:0] d_q;
  logic [TAGW-1:0] tag_mem [SETS];
  logic [TSW-1:0]  ts_mem  [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      if (wr_v_en) v_q[wr_set] <= wr_v;
      if (wr_d_en) d_q[wr_set] <= wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tag_en) tag_mem[wr_set] <= wr_tag;
    if (wr_ts_en)  ts_mem[wr_set]  <= wr_ts;
  end

  assign rd_valid = v_q[rd_set];
  assign rd_dirty = d_q[rd_set];
  assign rd_tag   = tag_mem[rd_set];
  assign rd_ts    = ts_mem[rd_set];

endmodule

// File: rtl/cmc_victim.sv
// Way selection for set-line: lowest invalid way, else oldest stamp
// (lowest index wins a tie).
module cmc_victim #(
  parameter int WAYS = 4,
  parameter int TSW  = 16
) (
  input  logic [WAYS-1:0]        valid,
  input  logic [WAYS*TSW-1:0]    ts_flat,
  output logic [$clog2(WAYS)-1:0] pick,
  output logic                   pick_free
);

  localparam int WAYW = $clog2(WAYS);

  logic [TSW-1:0] best;

  always_comb begin
    pick      = '0;
    pick_free = 1'b0;
    best      = ts_flat[0 +: TSW];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        pick      = WAYW'(w);
        pick_free = 1'b1;
      end
    end
    if (!pick_free) begin
      pick = '0;
      for (int w = 1; w < WAYS; w++) begin
        if (ts_flat[w*TSW +: TSW] < best) begin
          best = ts_flat[w*TSW +: TSW];
          pick = WAYW'(w);
        end
      end
    end
  end

endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
  import cmc_pkg::*;
#(
  parameter int ADDRW = 32,
  parameter int DATAW = 32,
  parameter int WAYS  = 4,
  parameter int SETS  = 64,
  parameter int WORDS = 8,
  parameter int TSW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_req,
  input  logic [2:0]               op_code,
  input  logic [ADDRW-1:0]         op_addr,
  input  logic                     bus_gnt,
  input  logic                     st_req,
  input  logic [ADDRW-1:0]         st_addr,
  input  logic [DATAW-1:0]         dat_rdata,
  output logic                     op_ack,
  output logic                     op_stall,
  output logic                     bus_hold,
  output logic                     wb_valid,
  output logic [ADDRW-1:0]         wb_addr,
  output logic [DATAW-1:0]         wb_data,
  output logic [$clog2(WAYS)-1:0]  dat_way,
  output logic [$clog2(SETS)-1:0]  dat_set,
  output logic [$clog2(WORDS)-1:0] dat_word
);

  localparam int WAYW  = $clog2(WAYS);
  localparam int SETW  = $clog2(SETS);
  localparam int WORDW = $clog2(WORDS);
  localparam int BYTEW = $clog2(DATAW / 8);
  localparam int TAGW  = ADDRW - SETW - WORDW - BYTEW;
  localparam int CNTW  = $clog2(WORDS + 1);
  localparam int SETLO = BYTEW + WORDW;

  mst_e            state_q;
  logic [CNTW-1:0] cnt_q;
  logic [TSW-1:0]  tick_q;
  logic [TAGW-1:0] f_tag_q;
  logic [TAGW-1:0] f_newtag_q;
  logic            f_inval_q;
  logic            f_inst_q;

  // lookup address: the request has the port when present
  logic [SETW-1:0] lk_set;
  logic [TAGW-1:0] lk_tag;
  assign lk_set = op_req ? op_addr[SETLO +: SETW] : st_addr[SETLO +: SETW];
  assign lk_tag = op_req ? op_addr[ADDRW-1 -: TAGW] : st_addr[ADDRW-1 -: TAGW];

  logic unused_low_bits;
  assign unused_low_bits = ^{op_addr[SETLO-1:0], st_addr[SETLO-1:0]};

  // per-way read/write signals
  logic [WAYS-1:0]     w_valid, w_dirty, w_hit;
  logic [TAGW-1:0]     w_tag [WAYS];
  logic [WAYS*TSW-1:0] w_ts_flat;
  logic [WAYS-1:0]     wv_en, wv, wd_en, wd, wt_en, ws_en;
  logic [SETW-1:0]     wr_set;
  logic [TAGW-1:0]     wr_tag;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    cmc_way #(.SETS(SETS), .TAGW(TAGW), .TSW(TSW)) u_way (
      .clk       (clk),
      .rst       (rst),
      .rd_set    (lk_set),
      .rd_valid  (w_valid[g]),
      .rd_dirty  (w_dirty[g]),
      .rd_tag    (w_tag[g]),
      .rd_ts     (w_ts_flat[g*TSW +: TSW]),
      .wr_set    (wr_set),
      .wr_v_en   (wv_en[g]),
      .wr_v      (wv[g]),
      .wr_d_en   (wd_en[g]),
      .wr_d      (wd[g]),
      .wr_tag_en (wt_en[g]),
      .wr_tag    (wr_tag),
      .wr_ts_en  (ws_en[g]),
      .wr_ts     (tick_q)
    );
    assign w_hit[g] = w_valid[g] && (w_tag[g] == lk_tag);
  end

  logic            hit_any;
  logic [WAYW-1:0] hit_way;
  always_comb begin
    hit_any = |w_hit;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (w_hit[w]) hit_way = WAYW'(w);
    end
  end

  logic [WAYW-1:0] vic_way;
  logic            vic_free;
  cmc_victim #(.WAYS(WAYS), .TSW(TSW)) u_victim (
    .valid     (w_valid),
    .ts_flat   (w_ts_flat),
    .pick      (vic_way),
    .pick_free (vic_free)
  );

  mop_e            opc;
  logic            take;
  logic            go_flush;
  logic            inval_n;
  logic            install_n;
  logic [WAYW-1:0] tgt_way;

  assign opc  = mop_e'(op_code);
  assign take = (state_q == ST_IDLE) && op_req && bus_gnt;

  always_comb begin
    wv_en     = '0;
    wv        = '0;
    wd_en     = '0;
    wd        = '0;
    wt_en     = '0;
    ws_en     = '0;
    wr_set    = lk_set;
    wr_tag    = lk_tag;
    tgt_way   = hit_way;
    go_flush  = 1'b0;
    inval_n   = 1'b0;
    install_n = 1'b0;
    if (state_q == ST_FLUSH) begin
      wr_set = dat_set;
      wr_tag = f_newtag_q;
      if (cnt_q == CNTW'(1)) begin
        wd_en[dat_way] = 1'b1;
        if (f_inval_q) wv_en[dat_way] = 1'b1;
        if (f_inst_q) begin
          wv_en[dat_way] = 1'b1;
          wv[dat_way]    = 1'b1;
          wt_en[dat_way] = 1'b1;
          ws_en[dat_way] = 1'b1;
        end
      end
    end else if (take) begin
      inval_n = (opc == OP_HIT_WBINV) || (opc == OP_FWBINV);
      unique case (opc)
        OP_HIT_INV: if (hit_any) wv_en[hit_way] = 1'b1;
        OP_HIT_WB, OP_HIT_WBINV: if (hit_any && w_dirty[hit_way]) go_flush = 1'b1;
        OP_FWB, OP_FWBINV: if (hit_any) go_flush = 1'b1;
        OP_SETLINE: begin
          if (!hit_any) begin
            tgt_way = vic_way;
            if (!vic_free && w_dirty[vic_way]) begin
              go_flush  = 1'b1;
              install_n = 1'b1;
            end else begin
              wv_en[vic_way] = 1'b1;
              wv[vic_way]    = 1'b1;
              wd_en[vic_way] = 1'b1;
              wt_en[vic_way] = 1'b1;
              ws_en[vic_way] = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if ((state_q == ST_IDLE) && st_req && !op_req) begin
      if (hit_any) begin
        wd_en[hit_way] = 1'b1;
        wd[hit_way]    = 1'b1;
        ws_en[hit_way] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      tick_q     <= '0;
      f_tag_q    <= '0;
      f_newtag_q <= '0;
      f_inval_q  <= 1'b0;
      f_inst_q   <= 1'b0;
      op_ack     <= 1'b0;
      op_stall   <= 1'b0;
      bus_hold   <= 1'b0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
      dat_way    <= '0;
      dat_set    <= '0;
      dat_word   <= '0;
    end else begin
      tick_q   <= tick_q + TSW'(1);
      op_ack   <= take;
      op_stall <= op_req && !take;
      wb_valid <= 1'b0;
      if (state_q == ST_FLUSH) begin
        wb_valid <= 1'b1;
        wb_addr  <= {f_tag_q, dat_set, dat_word, {BYTEW{1'b0}}};
        wb_data  <= dat_rdata;
        dat_word <= dat_word + WORDW'(1);
        cnt_q    <= cnt_q - CNTW'(1);
        bus_hold <= 1'b1;
        if (cnt_q == CNTW'(1)) state_q <= ST_IDLE;
      end else begin
        bus_hold <= go_flush;
        if (go_flush) begin
          state_q    <= ST_FLUSH;
          cnt_q      <= CNTW'(WORDS);
          dat_way    <= tgt_way;
          dat_set    <= lk_set;
          dat_word   <= '0;
          f_tag_q    <= w_tag[tgt_way];
          f_newtag_q <= lk_tag;
          f_inval_q  <= inval_n;
          f_inst_q   <= install_n;
        end
      end
    end
  end

endmodule

// File: rtl/cache_maint_ctrl_chk.sv
module cache_maint_ctrl_chk #(
  parameter int ADDRW = 32,
  parameter int WORDS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_req,
  input logic             bus_gnt,
  input logic             op_ack,
  input logic             op_stall,
  input logic             bus_hold,
  input logic             wb_valid,
  input logic [ADDRW-1:0] wb_addr
);

  logic [15:0] beats_q;
  always_ff @(posedge clk) begin
    if (rst) beats_q <= '0;
    else     beats_q <= wb_valid ? beats_q + 16'd1 : 16'd0;
  end

  AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    op_ack |-> $past(op_req && bus_gnt));                              // R1
  AST_ACK_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(op_ack && op_stall));                                            // R1
  AST_STALL_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
    op_stall |-> $past(op_req));                                       // R1
  AST_BEAT_HAS_BUS: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> bus_hold);                                            // R5
  AST_BEAT_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && $past(wb_valid)) |-> (wb_addr == $past(wb_addr) + ADDRW'(4))); // R5
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(wb_valid) |-> (beats_q == 16'(WORDS)));                      // R5
  AST_RELEASE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_hold) |-> $past(wb_valid));                              // R5

endmodule

bind cache_maint_ctrl cache_maint_ctrl_chk #(.ADDRW(ADDRW), .WORDS(WORDS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_req   (op_req),
  .bus_gnt  (bus_gnt),
  .op_ack   (op_ack),
  .op_stall (op_stall),
  .bus_hold (bus_hold),
  .wb_valid (wb_valid),
  .wb_addr  (wb_addr)
);

// File: tb/sim_cache_maint_ctrl.sv
`timescale 1ns/1ps
module sim_cache_maint_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_req = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_addr = '0;
  logic        bus_gnt = 1'b1;
  logic        st_req = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] dat_rdata;
  logic        op_ack, op_stall, bus_hold, wb_valid;
  logic [31:0] wb_addr, wb_data;
  logic [1:0]  dat_way;
  logic [5:0]  dat_set;
  logic [2:0]  dat_word;

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(int w, int s, int k);
    return 32'hD000_0000 | 32'(w << 16) | 32'(s << 8) | 32'(k);
  endfunction

  assign dat_rdata = pat(int'(dat_way), int'(dat_set), int'(dat_word));

  cache_maint_ctrl u0 (
    .clk(clk), .rst(rst), .op_req(op_req), .op_code(op_code), .op_addr(op_addr),
    .bus_gnt(bus_gnt), .st_req(st_req), .st_addr(st_addr), .dat_rdata(dat_rdata),
    .op_ack(op_ack), .op_stall(op_stall), .bus_hold(bus_hold), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data), .dat_way(dat_way), .dat_set(dat_set),
    .dat_word(dat_word)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit  mv [4][64];
  bit  md [4][64];
  int  mt [4][64];
  int  mts[4][64];
  int  tick;
  bit  m_busy, m_inv, m_ins;
  int  m_cnt, m_word, m_way, m_set, m_tag, m_new;
  bit  e_ack, e_stall, e_hold, e_wbv;
  logic [31:0] e_wba, e_wbd;
  int  s, t, hw, vw;
  bit  hit, fwb;

  always @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < 4; w++)
        for (int k = 0; k < 64; k++) begin
          mv[w][k] = 0; md[w][k] = 0; mt[w][k] = 0; mts[w][k] = 0;
        end
      tick = 0; m_busy = 0;
      e_ack = 0; e_stall = 0; e_hold = 0; e_wbv = 0;
    end else begin
      e_ack = 0; e_stall = 0; e_wbv = 0;
      if (m_busy) begin
        e_hold = 1; e_wbv = 1;
        e_wba = {21'(m_tag), 6'(m_set), 3'(m_word), 2'b00};
        e_wbd = pat(m_way, m_set, m_word);
        m_word++; m_cnt--;
        if (op_req) e_stall = 1;
        if (m_cnt == 0) begin
          md[m_way][m_set] = 0;
          if (m_inv) mv[m_way][m_set] = 0;
          if (m_ins) begin
            mv[m_way][m_set] = 1; mt[m_way][m_set] = m_new; mts[m_way][m_set] = tick;
          end
          m_busy = 0;
        end
      end else begin
        e_hold = 0;
        if (op_req) begin
          if (!bus_gnt) e_stall = 1;
          else begin
            e_ack = 1;
            s = int'(op_addr[10:5]); t = int'(op_addr[31:11]);
            hit = 0; hw = 0;
            for (int w = 3; w >= 0; w--) if (mv[w][s] && mt[w][s] == t) begin hit = 1; hw = w; end
            fwb = 0; m_ins = 0;
            m_inv = (op_code == 3'd2) || (op_code == 3'd4);
            case (op_code)
              3'd0: if (hit) mv[hw][s] = 0;
              3'd1, 3'd2: if (hit && md[hw][s]) fwb = 1;
              3'd3, 3'd4: if (hit) fwb = 1;
              3'd5: if (!hit) begin
                vw = -1;
                for (int w = 3; w >= 0; w--) if (!mv[w][s]) vw = w;
                if (vw < 0) begin
                  vw = 0;
                  for (int w = 1; w < 4; w++) if (mts[w][s] < mts[vw][s]) vw = w;
                end
                hw = vw;
                if (mv[vw][s] && md[vw][s]) begin fwb = 1; m_ins = 1; end
                else begin
                  mv[vw][s] = 1; md[vw][s] = 0; mt[vw][s] = t; mts[vw][s] = tick;
                end
              end
              default: ;
            endcase
            if (fwb) begin
              m_busy = 1; e_hold = 1; m_cnt = 8; m_word = 0;
              m_way = hw; m_set = s; m_tag = mt[hw][s]; m_new = t;
            end
          end
        end else if (st_req) begin
          s = int'(st_addr[10:5]); t = int'(st_addr[31:11]);
          for (int w = 0; w < 4; w++)
            if (mv[w][s] && mt[w][s] == t) begin md[w][s] = 1; mts[w][s] = tick; end
        end
      end
      tick++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1 ack", 32'(op_ack), 32'(e_ack));
      chk("R1 stall", 32'(op_stall), 32'(e_stall));
      chk("R5 hold", 32'(bus_hold), 32'(e_hold));
      chk("R5 beat", 32'(wb_valid), 32'(e_wbv));
      if (e_wbv) begin
        chk("R11 beat addr", wb_addr, e_wba);
        chk("R5 beat data", wb_data, e_wbd);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mk(int tg, int st);
    return {21'(tg), 6'(st), 5'd0};
  endfunction

  task automatic do_op(input logic [2:0] c, input logic [31:0] a,
                       output int beats, output logic [31:0] first);
    bit got = 0;
    for (int tries = 0; tries < 20 && !got; tries++) begin
      @(negedge clk); op_req = 1; op_code = c; op_addr = a;
      @(negedge clk); op_req = 0;
      got = op_ack;
    end
    beats = 0; first = '0;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (wb_valid) begin
        if (beats == 0) first = wb_addr;
        beats++;
      end
    end
  endtask

  task automatic st(input logic [31:0] a);
    @(negedge clk); st_req = 1; st_addr = a;
    @(negedge clk); st_req = 0;
  endtask

  initial begin : wdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int b;
    logic [31:0] fa;
    logic [31:0] A, B, C, D, E, P0, Q, M;
    A = mk(1, 3); B = mk(2, 3); C = mk(3, 3); D = mk(4, 3); E = mk(5, 3);
    M = mk(9, 3); P0 = mk(10, 7); Q = mk(14, 7);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset ack", 32'(op_ack), 0);
    chk("R5 reset hold", 32'(bus_hold), 0);

    // R7: fill set 3 with four fresh tags
    do_op(3'd5, A, b, fa); chk("R7 install", b, 0);
    do_op(3'd5, B, b, fa); chk("R7 install", b, 0);
    do_op(3'd5, C, b, fa); chk("R7 install", b, 0);
    do_op(3'd5, D, b, fa); chk("R7 install", b, 0);
    // R9: stores make lines dirty
    st(A); st(C);
    do_op(3'd1, B, b, fa); chk("R3 clean hit", b, 0);
    do_op(3'd1, A, b, fa); chk("R3 dirty hit", b, 8); chk("R11 line base", fa, A);
    do_op(3'd1, A, b, fa); chk("R6 dirty cleared", b, 0);
    do_op(3'd3, B, b, fa); chk("R4 forced clean", b, 8);
    do_op(3'd1, M, b, fa); chk("R3 miss", b, 0);
    do_op(3'd2, C, b, fa); chk("R3 wbinv", b, 8);
    do_op(3'd3, C, b, fa); chk("R6 valid cleared", b, 0);
    do_op(3'd5, E, b, fa); chk("R7 first invalid", b, 0);
    do_op(3'd3, E, b, fa); chk("R7 new tag", b, 8); chk("R7 addr", fa, E);
    do_op(3'd0, D, b, fa); chk("R2 inv", b, 0);
    do_op(3'd3, D, b, fa); chk("R2 gone", b, 0);
    do_op(3'd0, M, b, fa); chk("R2 miss", b, 0);
    do_op(3'd3, A, b, fa); chk("R2 untouched", b, 8);
    do_op(3'd5, A, b, fa); chk("R7 hit no effect", b, 0);
    do_op(3'd3, A, b, fa); chk("R7 still present", b, 8);

    // R8: dirty oldest way is flushed then replaced
    do_op(3'd5, P0, b, fa); st(P0);
    do_op(3'd5, mk(11, 7), b, fa);
    do_op(3'd5, mk(12, 7), b, fa);
    do_op(3'd5, mk(13, 7), b, fa);
    do_op(3'd5, Q, b, fa); chk("R8 evict dirty", b, 8); chk("R8 old addr", fa, P0);
    do_op(3'd3, Q, b, fa); chk("R8 installed", b, 8); chk("R8 new addr", fa, Q);
    do_op(3'd1, Q, b, fa); chk("R8 clean", b, 0);
    do_op(3'd1, P0, b, fa); chk("R8 old gone", b, 0);
    // R8: clean oldest way replaced at once
    do_op(3'd5, mk(15, 7), b, fa); chk("R8 clean evict", b, 0);
    do_op(3'd3, mk(11, 7), b, fa); chk("R8 oldest left", b, 0);

    // R10: reserved codes
    do_op(3'd6, A, b, fa); chk("R10 code6", b, 0);
    do_op(3'd7, A, b, fa); chk("R10 code7", b, 0);
    do_op(3'd3, A, b, fa); chk("R10 no effect", b, 8);

    // R9: store ignored on miss and when a request is present
    st(mk(20, 3));
    do_op(3'd1, mk(20, 3), b, fa); chk("R9 miss store", b, 0);
    @(negedge clk); op_req = 1; op_code = 3'd0; op_addr = M; st_req = 1; st_addr = B;
    @(negedge clk); op_req = 0; st_req = 0;
    chk("R1 ack", 32'(op_ack), 1);
    do_op(3'd1, B, b, fa); chk("R9 ignored store", b, 0);
    st(B);
    do_op(3'd1, B, b, fa); chk("R9 store dirty", b, 8);

    // R1: stall without grant
    bus_gnt = 0;
    @(negedge clk); op_req = 1; op_code = 3'd0; op_addr = A;
    @(negedge clk); op_req = 0;
    chk("R1 stall no grant", 32'(op_stall), 1);
    bus_gnt = 1;
    // R1: stall while flushing
    @(negedge clk); op_req = 1; op_code = 3'd3; op_addr = A;
    @(negedge clk); op_code = 3'd0;
    chk("R1 accept", 32'(op_ack), 1);
    @(negedge clk); op_req = 0;
    chk("R1 stall busy", 32'(op_stall), 1);
    repeat (12) @(negedge clk);
    do_op(3'd1, A, b, fa); chk("R1 refused had no effect", b, 0);
    do_op(3'd4, A, b, fa); chk("R4 forced inv", b, 8);
    do_op(3'd3, A, b, fa); chk("R6 forced inv gone", b, 0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule